// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block forms the memory address for a load or store and, alongside it, the value that the base register should hold afterwards. The caller hands over the base register contents, a 12-bit unsigned immediate, an index register value with a left-shift count, a selector for the offset source, a direction bit and an indexing mode. One cycle later the block returns the address for memory, the updated base value and a strobe saying whether that updated base must be written back.

Three indexing modes share a single adder. In plain offset mode the sum goes to memory and the base is left alone. In pre-index mode the sum goes to memory and is also written back. In post-index mode memory sees the untouched base and the sum is written back. The offset source can be nothing, the immediate, the index register, or the index register shifted left. All arithmetic wraps modulo 2^32 and no overflow is reported.

Top module: `agu_top`

## Requirements
- R1: An operation presented with `validIn` high at a rising edge appears on the outputs after that edge, with `validOut` high for exactly that one cycle. `validOut` is low in any cycle that follows an edge where `validIn` was low. Reset clears `validOut`, `wbEn`, `addrOut` and `newBaseOut` to zero.
- R2: The offset depends on `offSrc`: 0 gives zero, 1 gives `immIn` zero-extended to 32 bits, 2 gives `indexIn`, and 3 gives `indexIn` shifted left by `shiftAmt`.
- R3: When `upDown` is 1 the offset is added to the base. When it is 0 the offset is subtracted. The result wraps modulo 2^32 and no flag is raised.
- R4: Indexing mode 0 (plain offset) gives `addrOut` = base±offset, `newBaseOut` = base unchanged and `wbEn` = 0.
- R5: Indexing mode 1 (pre-index) gives `addrOut` = `newBaseOut` = base±offset and `wbEn` = 1.
- R6: Indexing mode 2 (post-index) gives `addrOut` = base unchanged, `newBaseOut` = base±offset and `wbEn` = 1.
- R7: Indexing mode code 3 behaves exactly like plain offset mode (R4).
- R8: In a cycle that follows an edge where `validIn` was low, `addrOut` and `newBaseOut` keep their previous values and `wbEn` is 0, whatever the other inputs carry.
- R9: In the scaled offset, shift counts from 0 to 31 are honoured. Bits shifted past bit 31 are discarded.
- R10: With offset source 0, both outputs equal the base in every indexing mode, for either value of `upDown`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| validIn | input | 1 | Operation present on the inputs |
| baseIn | input | 32 | Base register value |
| immIn | input | 12 | Unsigned immediate offset |
| indexIn | input | 32 | Index register value |
| shiftAmt | input | 5 | Left-shift count for the scaled index |
| offSrc | input | 2 | Offset source: 0 none, 1 immediate, 2 register, 3 scaled register |
| upDown | input | 1 | 1 add offset, 0 subtract offset |
| idxMode | input | 2 | 0 plain offset, 1 pre-index, 2 post-index, 3 treated as 0 |
| validOut | output | 1 | Results valid this cycle |
| addrOut | output | 32 | Effective memory address |
| newBaseOut | output | 32 | Value for the base register after the access |
| wbEn | output | 1 | Base register writeback required |

## Verification
All state is one register stage, so any wrong strobe or mux decision becomes visible on the cycle right after the operation is accepted. A mis-decoded indexing mode shows as `addrOut` and `newBaseOut` swapping roles, or as a `wbEn` that disagrees with the mode. A wrong offset source or direction shows as a sum that differs from the reference arithmetic. A capture enable that fires when it should not shows as outputs that change, or as a `wbEn` pulse, during idle cycles. The bench compares every result against an independent arithmetic model in the cycle after issue. It also checks the held values during idle stretches.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    OFS_NONE   = 2'd0,
    OFS_IMM    = 2'd1,
    OFS_REG    = 2'd2,
    OFS_SCALED = 2'd3
  } offSrc_e;

  typedef enum logic [1:0] {
    IDX_OFFSET = 2'd0,
    IDX_PRE    = 2'd1,
    IDX_POST   = 2'd2,
    IDX_RSVD   = 2'd3
  } idxMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;      // load the output registers this cycle
    logic selImm;       // offset is the zero-extended immediate
    logic selReg;       // offset is the raw index register
    logic selScaled;    // offset is the shifted index register
    logic subtract;     // base minus offset instead of base plus offset
    logic addrFromSum;  // memory address takes the sum, else the raw base
    logic baseFromSum;  // new base takes the sum, else the raw base
  } aguCtl_t;

endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       validIn,
  input  logic [1:0] offSrc,
  input  logic       upDown,
  input  logic [1:0] idxMode,
  output aguCtl_t    ctl,
  output logic       validOut,
  output logic       wbEn
);

  logic isPre;
  logic isPost;
  logic wantWb;

  always_comb begin
    isPre  = (idxMode == IDX_PRE);
    isPost = (idxMode == IDX_POST);
    wantWb = isPre | isPost;

    ctl.capture     = validIn;
    ctl.selImm      = (offSrc == OFS_IMM);
    ctl.selReg      = (offSrc == OFS_REG);
    ctl.selScaled   = (offSrc == OFS_SCALED);
    ctl.subtract    = ~upDown;
    // post-index presents the untouched base; reserved code acts as offset
    ctl.addrFromSum = ~isPost;
    ctl.baseFromSum = wantWb;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validOut <= 1'b0;
      wbEn     <= 1'b0;
    end else begin
      validOut <= validIn;
      wbEn     <= validIn & wantWb;
    end
  end

endmodule

// File: rtl/agu_dp.sv
module agu_dp
  import agu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12,
  localparam int SH_W  = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  aguCtl_t           ctl,
  input  logic [ADDR_W-1:0] baseIn,
  input  logic [IMM_W-1:0]  immIn,
  input  logic [ADDR_W-1:0] indexIn,
  input  logic [SH_W-1:0]   shiftAmt,
  output logic [ADDR_W-1:0] addrOut,
  output logic [ADDR_W-1:0] newBaseOut
);

  localparam int PAD_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] immExt;
  logic [ADDR_W-1:0] scaledIdx;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] sum;

  generate
    if (PAD_W > 0) begin : g_immPad
      assign immExt = {{PAD_W{1'b0}}, immIn};
    end else begin : g_immTrunc
      assign immExt = immIn[ADDR_W-1:0];
    end
  endgenerate

  // left shift, bits beyond the top are dropped
  assign scaledIdx = indexIn << shiftAmt;

  always_comb begin
    offset = '0;
    if (ctl.selImm)    offset = immExt;
    if (ctl.selReg)    offset = indexIn;
    if (ctl.selScaled) offset = scaledIdx;
  end

  assign sum = ctl.subtract ? (baseIn - offset) : (baseIn + offset);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrOut    <= '0;
      newBaseOut <= '0;
    end else if (ctl.capture) begin
      addrOut    <= ctl.addrFromSum ? sum : baseIn;
      newBaseOut <= ctl.baseFromSum ? sum : baseIn;
    end
  end

endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12,
  localparam int SH_W  = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [ADDR_W-1:0] baseIn,
  input  logic [IMM_W-1:0]  immIn,
  input  logic [ADDR_W-1:0] indexIn,
  input  logic [SH_W-1:0]   shiftAmt,
  input  logic [1:0]        offSrc,
  input  logic              upDown,
  input  logic [1:0]        idxMode,
  output logic              validOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic [ADDR_W-1:0] newBaseOut,
  output logic              wbEn
);

  aguCtl_t ctl;

  agu_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .offSrc   (offSrc),
    .upDown   (upDown),
    .idxMode  (idxMode),
    .ctl      (ctl),
    .validOut (validOut),
    .wbEn     (wbEn)
  );

  agu_dp #(
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .baseIn     (baseIn),
    .immIn      (immIn),
    .indexIn    (indexIn),
    .shiftAmt   (shiftAmt),
    .addrOut    (addrOut),
    .newBaseOut (newBaseOut)
  );

endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              validIn,
  input logic [ADDR_W-1:0] baseIn,
  input logic [ADDR_W-1:0] indexIn,
  input logic [1:0]        offSrc,
  input logic              upDown,
  input logic [1:0]        idxMode,
  input logic              validOut,
  input logic [ADDR_W-1:0] addrOut,
  input logic [ADDR_W-1:0] newBaseOut,
  input logic              wbEn
);

  // set from the first edge after reset, so $past never reaches before it
  logic armed;
  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rstN || !armed)
    validOut == $past(validIn));

  assert_wb_needs_valid_R1: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> validOut);

  assert_reg_add_pre_R2: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && offSrc == 2'd2 && upDown && idxMode == 2'd1)
      |=> (addrOut == $past(baseIn) + $past(indexIn)));

  assert_plain_keeps_base_R4: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && (idxMode == 2'd0 || idxMode == 2'd3))
      |=> (!wbEn && newBaseOut == $past(baseIn)));

  assert_pre_same_sum_R5: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && idxMode == 2'd1) |=> (wbEn && addrOut == newBaseOut));

  assert_post_raw_addr_R6: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && idxMode == 2'd2) |=> (wbEn && addrOut == $past(baseIn)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> (!wbEn && $stable(addrOut) && $stable(newBaseOut)));

  assert_none_offset_R10: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && offSrc == 2'd0)
      |=> (addrOut == $past(baseIn) && newBaseOut == $past(baseIn)));

endmodule

bind agu_top agu_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .validIn    (validIn),
  .baseIn     (baseIn),
  .indexIn    (indexIn),
  .offSrc     (offSrc),
  .upDown     (upDown),
  .idxMode    (idxMode),
  .validOut   (validOut),
  .addrOut    (addrOut),
  .newBaseOut (newBaseOut),
  .wbEn       (wbEn)
);

// File: tb/agu_top_tb_top.sv
`timescale 1ns/1ps
module agu_top_tb_top;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] nb;
    logic        wb;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [31:0] baseIn = '0;
  logic [11:0] immIn = '0;
  logic [31:0] indexIn = '0;
  logic [4:0]  shiftAmt = '0;
  logic [1:0]  offSrc = '0;
  logic        upDown = 1'b0;
  logic [1:0]  idxMode = '0;
  logic        validOut;
  logic [31:0] addrOut;
  logic [31:0] newBaseOut;
  logic        wbEn;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit monOn = 0;
  bit seenAny = 0;
  logic [31:0] lastAddr = '0;
  logic [31:0] lastNb = '0;
  expItem_t q[$];

  always #2.5 clk = ~clk;

  agu_top dut_i (
    .clk(clk), .rstN(rstN), .validIn(validIn), .baseIn(baseIn),
    .immIn(immIn), .indexIn(indexIn), .shiftAmt(shiftAmt),
    .offSrc(offSrc), .upDown(upDown), .idxMode(idxMode),
    .validOut(validOut), .addrOut(addrOut), .newBaseOut(newBaseOut),
    .wbEn(wbEn)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference arithmetic straight from the requirements
  function automatic expItem_t model(input logic [31:0] b, input logic [11:0] im,
      input logic [31:0] ix, input logic [4:0] sh, input logic [1:0] src,
      input logic up, input logic [1:0] md, input string tag);
    expItem_t e;
    logic [31:0] off;
    logic [31:0] s;
    case (src)
      2'd0: off = 32'd0;
      2'd1: off = {20'd0, im};
      2'd2: off = ix;
      default: off = ix << sh;
    endcase
    s = up ? b + off : b - off;
    case (md)
      2'd1: begin e.addr = s; e.nb = s; e.wb = 1'b1; end
      2'd2: begin e.addr = b; e.nb = s; e.wb = 1'b1; end
      default: begin e.addr = s; e.nb = b; e.wb = 1'b0; end
    endcase
    e.tag = tag;
    return e;
  endfunction

  task automatic issue(input logic [31:0] b, input logic [11:0] im,
      input logic [31:0] ix, input logic [4:0] sh, input logic [1:0] src,
      input logic up, input logic [1:0] md, input string tag);
    @(negedge clk);
    validIn = 1'b1; baseIn = b; immIn = im; indexIn = ix;
    shiftAmt = sh; offSrc = src; upDown = up; idxMode = md;
    q.push_back(model(b, im, ix, sh, src, up, md, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      validIn = 1'b0;
      // garbage that must be ignored (R8)
      baseIn = 32'hDEAD_0000 + i; indexIn = 32'h1234_5678; immIn = 12'hABC;
      offSrc = 2'd1; idxMode = 2'd1; upDown = 1'b1; shiftAmt = 5'd3;
    end
  endtask

  // monitor: compares one cycle after each issue, checks holds when idle
  always @(negedge clk) begin
    if (monOn) begin
      if (validOut) begin
        if (q.size() == 0) begin
          check(1'b0, "R1 unexpected validOut", 32'd1, 32'd0);
        end else begin
          expItem_t e;
          e = q.pop_front();
          check(addrOut == e.addr, {e.tag, " addr"}, addrOut, e.addr);
          check(newBaseOut == e.nb, {e.tag, " newBase"}, newBaseOut, e.nb);
          check(wbEn == e.wb, {e.tag, " wbEn"}, {31'd0, wbEn}, {31'd0, e.wb});
          lastAddr = e.addr; lastNb = e.nb; seenAny = 1'b1;
        end
      end else begin
        check(wbEn == 1'b0, "R8 wbEn idle", {31'd0, wbEn}, 32'd0);
        if (seenAny) begin
          check(addrOut == lastAddr, "R8 addr hold", addrOut, lastAddr);
          check(newBaseOut == lastNb, "R8 newBase hold", newBaseOut, lastNb);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(validOut == 1'b0, "R1 reset validOut", {31'd0, validOut}, 32'd0);
    check(wbEn == 1'b0, "R1 reset wbEn", {31'd0, wbEn}, 32'd0);
    check(addrOut == 32'd0, "R1 reset addr", addrOut, 32'd0);
    check(newBaseOut == 32'd0, "R1 reset newBase", newBaseOut, 32'd0);
    monOn = 1;

    issue(32'h0000_1000, 12'h004, 32'h0, 5'd0, 2'd1, 1'b1, 2'd0, "R4 imm plain");
    issue(32'h0000_1000, 12'h004, 32'h0, 5'd0, 2'd1, 1'b1, 2'd1, "R5 imm pre");
    issue(32'h0000_1000, 12'h004, 32'h0, 5'd0, 2'd1, 1'b1, 2'd2, "R6 imm post");
    issue(32'h2000_0000, 12'hFFF, 32'h0, 5'd0, 2'd1, 1'b0, 2'd1, "R2 imm max sub");
    idle(2);
    issue(32'h0000_8000, 12'h0, 32'h0000_0100, 5'd0, 2'd2, 1'b1, 2'd0, "R2 reg plain");
    issue(32'h0000_8000, 12'h0, 32'h0000_0100, 5'd0, 2'd2, 1'b0, 2'd2, "R3 reg post sub");
    issue(32'h0000_8000, 12'h0, 32'h0000_0003, 5'd2, 2'd3, 1'b1, 2'd1, "R2 scaled pre");
    issue(32'h0000_0000, 12'h0, 32'h0000_0003, 5'd31, 2'd3, 1'b1, 2'd0, "R9 shift 31");
    issue(32'h1111_1111, 12'h0, 32'hFFFF_FFFF, 5'd4, 2'd3, 1'b0, 2'd2, "R9 bits dropped");
    idle(3);
    issue(32'hFFFF_FFF0, 12'h020, 32'h0, 5'd0, 2'd1, 1'b1, 2'd1, "R3 wrap up");
    issue(32'h0000_0004, 12'h008, 32'h0, 5'd0, 2'd1, 1'b0, 2'd2, "R3 wrap down");
    issue(32'h0000_4000, 12'h010, 32'h0, 5'd0, 2'd1, 1'b1, 2'd3, "R7 reserved imm");
    issue(32'h0000_4000, 12'h0, 32'h0000_0040, 5'd1, 2'd3, 1'b0, 2'd3, "R7 reserved scaled");
    issue(32'hCAFE_0000, 12'hFFF, 32'h5555_5555, 5'd7, 2'd0, 1'b0, 2'd1, "R10 none pre");
    issue(32'hCAFE_0000, 12'hFFF, 32'h5555_5555, 5'd7, 2'd0, 1'b1, 2'd2, "R10 none post");
    issue(32'hCAFE_0000, 12'hFFF, 32'h5555_5555, 5'd7, 2'd0, 1'b0, 2'd0, "R10 none plain");
    idle(4);
    @(negedge clk);
    check(q.size() == 0, "R1 all results returned", q.size(), 32'd0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule